// File: doc/BRIEF.md
# TDM Control and Status Serial Port

This block is the control side of a T1 line device that sits on a 2.048 Mbit/s time-division bus. The bus frame lasts 125 µs and carries 32 eight-bit timeslots; a low-going frame pulse marks where a frame begins. The block shifts in the serial control stream, pulls out 24 per-channel control bytes and two master control bytes, and presents them as parallel words. On the return path, it sends 24 per-channel status bytes, a phase status byte and two master status bytes onto the serial status stream.

The 24 line channels occupy the bus in runs of three, so every fourth slot carries no channel. The master and phase words use some of those spare slots. One master control bit drives an external control pin. An external status pin is sampled once per frame and returned inside a master status byte. Two master control bits choose the framing mode, which is reported as a two-bit code. The block only moves the words. It does not act on them.

Top module: `tdm_ctl_port`

## Requirements
- R1: A low `fp_n` seen on a rising edge of `clk` makes the next bit period the first bit of slot 0. Without a pulse, the block free-runs with a period of 256 bits.
- R2: `ctl_in` is sampled on falling edges, most significant bit first. Line channel c (0..23) is taken from slot 4*(c/3) + c%3 and shown on `pcc_words[8c+7:8c]`.
- R3: The byte received in slot 15 appears on `mcw1`, and the byte received in slot 31 appears on `mcw2`.
- R4: All control bytes received during a frame take effect together at the rising edge that ends the frame, or at a frame pulse. Until then, the parallel outputs keep the previous frame's values.
- R5: `ext_ctl` equals bit 3 of the applied `mcw1` and changes only at a frame boundary.
- R6: `mode` is 2'b10 when bit 4 of `mcw2` is set, whatever bit 2 holds. Otherwise `mode` is {1'b0, bit 2 of `mcw2`}.
- R7: `sts_out` changes on rising edges, most significant bit first. Line channel c sends `pcs_words[8c+7:8c]` in slot 4*(c/3) + c%3.
- R8: Slot 3 sends `psw`, slot 15 sends `msw1`, and slot 31 sends `msw2`, except for bit 5.
- R9: Bit 5 of slot 31 carries `ext_st`. `ext_st` and all status inputs are captured at the frame boundary, so changes during a frame only show in the next frame.
- R10: Slots 7, 11, 19, 23 and 27 send zeros.
- R11: After reset, all parallel control outputs, `mode` and `ext_ctl` are zero, and `sts_out` sends zeros until the first boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fp_n | input | 1 | Frame pulse, active low |
| ctl_in | input | 1 | Serial control stream |
| pcs_words | input | 192 | Per-channel status bytes, channel c at bits 8c+7:8c |
| psw | input | 8 | Phase status byte |
| msw1 | input | 8 | Master status byte 1 |
| msw2 | input | 8 | Master status byte 2 (bit 5 not used) |
| ext_st | input | 1 | External status pin |
| sts_out | output | 1 | Serial status stream |
| pcc_words | output | 192 | Applied per-channel control bytes |
| mcw1 | output | 8 | Applied master control byte 1 |
| mcw2 | output | 8 | Applied master control byte 2 |
| mode | output | 2 | Framing mode code |
| ext_ctl | output | 1 | External control pin |

## Verification
The bench compares every bit of the status stream over several frames. This catches a design that maps channels linearly instead of skipping every fourth slot, that sends bytes least significant bit first, or that leaks data into the idle slots. The bench changes the status inputs and the external status pin in the middle of each frame. A design that does not capture them at the boundary therefore sends a byte mixed from two frames. The control outputs are checked partway through a frame that has already shifted in new slots. A port that updates each word as it arrives fails at that point. The mode patterns include an ESF frame with bit 2 set and a non-ESF frame with bit 2 clear, which exposes a decoder that gives the wrong bit priority.

// File: rtl/tdm_ctl_port.sv
module tdm_ctl_port #(
  parameter int SLOTS = 32,
  parameter int BITS  = 8,
  parameter int CHANS = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fp_n,
  input  logic                  ctl_in,
  input  logic [CHANS*BITS-1:0] pcs_words,
  input  logic [BITS-1:0]       psw,
  input  logic [BITS-1:0]       msw1,
  input  logic [BITS-1:0]       msw2,
  input  logic                  ext_st,
  output logic                  sts_out,
  output logic [CHANS*BITS-1:0] pcc_words,
  output logic [BITS-1:0]       mcw1,
  output logic [BITS-1:0]       mcw2,
  output logic [1:0]            mode,
  output logic                  ext_ctl
);
  localparam int CW      = $clog2(SLOTS*BITS);
  localparam int BW      = $clog2(BITS);
  localparam int SW      = CW - BW;
  localparam int PS_SLOT = 3;
  localparam int M1_SLOT = SLOTS/2 - 1;
  localparam int M2_SLOT = SLOTS - 1;

  function automatic int chslot(int c);
    return (c/3)*4 + c%3;
  endfunction

  logic [CW-1:0]   cnt;
  logic [SW-1:0]   slot;
  logic [BW-1:0]   bidx;
  logic            bnd;
  logic [BITS-2:0] sh;
  logic [BITS-1:0] rx_byte;

  assign slot    = cnt[CW-1:BW];
  assign bidx    = cnt[BW-1:0];
  assign bnd     = !fp_n || (cnt == CW'(SLOTS*BITS-1));
  assign rx_byte = {sh, ctl_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     cnt <= '0;
    else if (!fp_n) cnt <= '0;
    else            cnt <= cnt + 1'b1;

  // R1
  frame_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fp_n |=> cnt == '0);

  logic [BITS-1:0] pend_pc [CHANS];
  logic [BITS-1:0] pend_m1, pend_m2;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) begin
      sh      <= '0;
      pend_m1 <= '0;
      pend_m2 <= '0;
      for (int c = 0; c < CHANS; c++) pend_pc[c] <= '0;
    end else begin
      sh <= rx_byte[BITS-2:0];
      if (bidx == BW'(BITS-1)) begin
        if (int'(slot) == M1_SLOT) pend_m1 <= rx_byte;
        if (int'(slot) == M2_SLOT) pend_m2 <= rx_byte;
        for (int c = 0; c < CHANS; c++)
          if (int'(slot) == chslot(c)) pend_pc[c] <= rx_byte;
      end
    end

  logic [BITS-1:0] act_pc [CHANS];
  logic [BITS-1:0] act_m1, act_m2;
  logic [CHANS*BITS-1:0] snap_pcs;
  logic [BITS-1:0] snap_ps, snap_m1, snap_m2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act_m1   <= '0;
      act_m2   <= '0;
      snap_pcs <= '0;
      snap_ps  <= '0;
      snap_m1  <= '0;
      snap_m2  <= '0;
      for (int c = 0; c < CHANS; c++) act_pc[c] <= '0;
    end else if (bnd) begin
      act_m1   <= pend_m1;
      act_m2   <= pend_m2;
      snap_pcs <= pcs_words;
      snap_ps  <= psw;
      snap_m1  <= msw1;
      snap_m2  <= {msw2[7:6], ext_st, msw2[4:0]};
      for (int c = 0; c < CHANS; c++) act_pc[c] <= pend_pc[c];
    end

  wire unused_msw2_b5 = msw2[5];

  for (genvar c = 0; c < CHANS; c++) begin : g_pcc
    assign pcc_words[c*BITS +: BITS] = act_pc[c];
  end
  assign mcw1    = act_m1;
  assign mcw2    = act_m2;
  assign ext_ctl = act_m1[3];
  assign mode    = act_m2[4] ? 2'b10 : {1'b0, act_m2[2]};

  // R4
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pcc_words) || !$stable(mcw1) || !$stable(mcw2)) |-> $past(bnd));

  // R5
  ext_ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ext_ctl) |-> $past(bnd));

  // R6
  esf_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mcw2[4] |-> mode == 2'b10);

  logic [BITS-1:0] obyte;
  always_comb begin
    obyte = '0;
    if (int'(slot) == PS_SLOT)      obyte = snap_ps;
    else if (int'(slot) == M1_SLOT) obyte = snap_m1;
    else if (int'(slot) == M2_SLOT) obyte = snap_m2;
    else
      for (int c = 0; c < CHANS; c++)
        if (int'(slot) == chslot(c)) obyte = snap_pcs[c*BITS +: BITS];
  end
  assign sts_out = obyte[BW'(BITS-1) - bidx];

  // R10
  idle_low_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (slot[1:0] == 2'b11 && int'(slot) != PS_SLOT && int'(slot) != M1_SLOT &&
     int'(slot) != M2_SLOT) |-> !sts_out);
endmodule

// File: tb/tb_tdm_ctl_port.sv
module tb_tdm_ctl_port;
  logic clk = 0, rst_n = 0, fp_n = 1, ctl_in = 0, ext_st = 0;
  logic [191:0] pcs_words;
  logic [7:0] psw, msw1, msw2;
  logic sts_out, ext_ctl;
  logic [191:0] pcc_words;
  logic [7:0] mcw1, mcw2;
  logic [1:0] mode;
  int checks = 0, errors = 0;
  bit done = 0;

  tdm_ctl_port dut (.clk(clk), .rst_n(rst_n), .fp_n(fp_n), .ctl_in(ctl_in),
    .pcs_words(pcs_words), .psw(psw), .msw1(msw1), .msw2(msw2), .ext_st(ext_st),
    .sts_out(sts_out), .pcc_words(pcc_words), .mcw1(mcw1), .mcw2(mcw2),
    .mode(mode), .ext_ctl(ext_ctl));

  always #5 clk = ~clk;

  typedef struct { logic v; string req; } item_t;
  item_t q[$];

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int chslot(int c);
    return (c/3)*4 + c%3;
  endfunction

  function automatic logic [7:0] cbyte(int f, int s);
    if (f < 0) return 8'h00;
    if (s == 15) case (f) 0: return 8'h08; 1: return 8'h00; 2: return 8'hF7;
                          3: return 8'h08; default: return 8'h00; endcase
    if (s == 31) case (f) 0: return 8'h04; 1: return 8'h14; 2: return 8'h10;
                          3: return 8'h00; default: return 8'hEB; endcase
    return 8'(s*37 + f*91 + 5);
  endfunction

  task automatic set_status(int k);
    for (int c = 0; c < 24; c++) pcs_words[c*8 +: 8] = 8'(c*53 + k*29 + 1);
    psw = 8'(k*17 + 3);
    msw1 = 8'(k*71 + 9);
    msw2 = 8'hFF ^ 8'(k);
    ext_st = (k % 2 == 0);
  endtask

  function automatic logic [7:0] sbyte(int s);
    if (s == 3) return psw;
    if (s == 15) return msw1;
    if (s == 31) return {msw2[7:6], ext_st, msw2[4:0]};
    if (s % 4 == 3) return 8'h00;
    return pcs_words[((s/4)*3 + s%4)*8 +: 8];
  endfunction

  task automatic check_ctrl(int pf, string tag);
    logic [7:0] m2;
    for (int c = 0; c < 24; c++)
      chk({"R2 ", tag}, pcc_words[c*8 +: 8], cbyte(pf, chslot(c)));
    chk({"R3 ", tag}, mcw1, cbyte(pf, 15));
    chk({"R3 ", tag}, mcw2, cbyte(pf, 31));
    chk({"R5 ", tag}, {7'd0, ext_ctl}, {7'd0, cbyte(pf, 15) & 8'h08 ? 1'b1 : 1'b0});
    m2 = cbyte(pf, 31);
    chk({"R6 ", tag}, {6'd0, mode}, m2[4] ? 8'd2 : {7'd0, m2[2]});
  endtask

  task automatic send_frame(int k);
    logic [7:0] exp_st [32];
    for (int b = 0; b < 256; b++) begin
      item_t it;
      #1;
      fp_n = 1;
      if (b == 0) for (int s = 0; s < 32; s++) exp_st[s] = sbyte(s);
      ctl_in = cbyte(k, b/8)[7 - b%8];
      it.v = exp_st[b/8][7 - b%8];
      if (k == 0 && b < 8) it.req = "R1";
      else if (b/8 == 31 && b%8 == 2) it.req = "R9";
      else if (b/8 == 3 || b/8 == 15 || b/8 == 31) it.req = "R8";
      else if ((b/8) % 4 == 3) it.req = "R10";
      else it.req = "R7";
      q.push_back(it);
      if (b == 128) set_status(k + 1);
      if (b == 0) begin #3; check_ctrl(k - 1, "boundary"); end
      if (b == 200) begin #3; check_ctrl(k - 1, "R4 mid-frame hold"); end
      @(posedge clk);
    end
  endtask

  always @(negedge clk) begin
    item_t it;
    if (q.size() != 0) begin
      it = q.pop_front();
      checks++;
      if (sts_out !== it.v) begin
        errors++;
        $display("FAIL %s status bit actual=%b expected=%b", it.req, sts_out, it.v);
      end
    end
  end

  initial begin
    set_status(0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (5) @(posedge clk);
    #4;
    chk("R11 pcc", pcc_words[7:0] | pcc_words[191:184], 8'h00);
    chk("R11 mcw", mcw1 | mcw2, 8'h00);
    chk("R11 mode/ext", {5'd0, mode, ext_ctl}, 8'h00);
    chk("R11 sts", {7'd0, sts_out}, 8'h00);
    @(posedge clk);
    #1 fp_n = 0;
    @(posedge clk);
    for (int k = 0; k < 5; k++) send_frame(k);
    #1 check_ctrl(4, "last");
    repeat (3) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule